// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a small serial memory. It watches a two-wire serial bus (a clock line and an open-drain data line) from inside a much faster system clock domain. It recognises the bus framing conditions and decodes the device command. It keeps the byte address pointer and answers read transfers from a synchronous byte read port. Each accepted write byte is handed to a separate write sequencer, together with a pulse when the closing STOP arrives. The sequencer reports back through a busy flag. The array itself and its programming timing belong to other blocks.

Both raw line inputs pass through a synchroniser and a majority-free stability filter before any edge is detected. The block only ever pulls the data line low through a single enable output. The memory size is a parameter, 128 or 256 bytes, and it also selects how the pointer behaves at the top address during a streaming read.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the data pull-down enable is low, no write strobe or STOP pulse is active, and the read address port shows 0.
- R2: A transfer begins only at a START (data falling while clock is high) and ends at a STOP (data rising while clock is high); clock pulses outside a transfer, or after a command that was not acknowledged, get no acknowledge and change no state until the next START.
- R3: A command byte is accepted only when bits 7..4 equal 1010; bits 3..1 are ignored; bit 0 = 0 selects write and bit 0 = 1 selects read.
- R4: Bits are taken on the clock rising edge, most significant first, and the pull-down enable changes only while the clock is low; the acknowledge is given during the ninth clock.
- R5: The byte after an accepted write command is acknowledged and its low log2(size) bits load the address pointer.
- R6: Each following write byte is acknowledged and produces a one-cycle write strobe carrying the pointer value and the byte; the pointer then advances within its 8-byte page (bits 2..0 wrap, upper bits kept).
- R7: A STOP produces a one-cycle STOP pulse to the write sequencer only if at least one write byte was accepted since the last START.
- R8: An accepted read command sends the byte at the pointer and advances the pointer; sending continues while the master acknowledges and ends at a master no-acknowledge; a repeated START after the address byte gives a random read, and a read with no address gives a current-address read.
- R9: While the busy input is high no command byte, read or write, is acknowledged.
- R10: With 256 bytes a streaming read wraps from address 255 to 0; with 128 bytes it stays at address 127 and keeps returning that byte.
- R11: A clock pulse shorter than the filter length (default 3 system cycles) is not seen as a bus edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line as seen on the wire |
| sda_pull | output | 1 | 1 = pull the data line low |
| busy | input | 1 | Write sequencer is programming |
| rd_addr | output | log2(MEM_BYTES) | Address presented to the read port |
| rd_data | input | 8 | Byte at rd_addr, one cycle after the address |
| wr_valid | output | 1 | One-cycle strobe for an accepted write byte |
| wr_addr | output | log2(MEM_BYTES) | Address of the write byte |
| wr_data | output | 8 | Write byte |
| wr_stop | output | 1 | One-cycle pulse at a STOP that closes a write |

## Verification
A pointer that is off by one shows up in the first read byte after the fault, since every read byte is compared against the byte model at the expected address, and the rollover and saturation corner is read across the top address. A wrong decode or phase state shows up in the acknowledge bit of the very next byte, which the bench samples on every byte it sends. A wrong write path shows up in the next write strobe, whose address and data are popped from an expected queue, or in a missing or extra STOP pulse counted at the end of each transfer.

// File: rtl/twi_pkg.sv
package twi_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CMD   = 3'd1,
      ST_ADDR  = 3'd2,
      ST_WDATA = 3'd3,
      ST_RDATA = 3'd4
   } twi_st_e;

   localparam logic [3:0] DEV_NIBBLE = 4'b1010;
   localparam int         PAGE_BITS  = 3;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 2) begin : g_bad_filt
         $error("FILT_LEN must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic [FILT_LEN-1:0]    hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         hist_q <= '1;
         clean  <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
         hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
         if (&hist_q)
            clean <= 1'b1;
         else if (~|hist_q)
            clean <= 1'b0;
      end
   end
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_c,
   input  logic sda_c,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_c;
         sda_q <= sda_c;
      end
   end

   assign scl_rise = scl_c & ~scl_q;
   assign scl_fall = ~scl_c & scl_q;
   assign start_ev = scl_c & scl_q & sda_q & ~sda_c;
   assign stop_ev  = scl_c & scl_q & ~sda_q & sda_c;
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
   parameter int AW   = 8,
   parameter bit ROLL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          inc_seq,
   input  logic          inc_page,
   output logic [AW-1:0] addr
);
   localparam int PB = twi_pkg::PAGE_BITS;

   logic [AW-1:0] seq_nxt;
   logic [AW-1:0] page_nxt;

   generate
      if (ROLL) begin : g_wrap
         assign seq_nxt = addr + 1'b1;
      end else begin : g_sat
         assign seq_nxt = (&addr) ? addr : addr + 1'b1;
      end
   endgenerate

   assign page_nxt = {addr[AW-1:PB], addr[PB-1:0] + 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= '0;
      else if (load)
         addr <= load_val;
      else if (inc_page)
         addr <= page_nxt;
      else if (inc_seq)
         addr <= seq_nxt;
   end
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
   parameter int MEM_BYTES   = 256,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3,
   localparam int AW         = $clog2(MEM_BYTES),
   localparam bit ROLL       = (MEM_BYTES == 256)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_in,
   input  logic          sda_in,
   output logic          sda_pull,
   input  logic          busy,
   output logic [AW-1:0] rd_addr,
   input  logic [7:0]    rd_data,
   output logic          wr_valid,
   output logic [AW-1:0] wr_addr,
   output logic [7:0]    wr_data,
   output logic          wr_stop
);
   import twi_pkg::*;

   generate
      if (MEM_BYTES != 128 && MEM_BYTES != 256) begin : g_bad_size
         $error("MEM_BYTES must be 128 or 256");
      end
   endgenerate

   logic [1:0] line_raw, line_c;
   logic       scl_c, sda_c;
   assign line_raw = {sda_in, scl_in};

   generate
      for (genvar i = 0; i < 2; i++) begin : g_line
         twi_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .raw(line_raw[i]), .clean(line_c[i]));
      end
   endgenerate

   assign scl_c = line_c[0];
   assign sda_c = line_c[1];

   logic scl_rise, scl_fall, start_ev, stop_ev;

   twi_bus_events u_ev (
      .clk(clk), .rst_n(rst_n), .scl_c(scl_c), .sda_c(sda_c),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev));

   twi_st_e    st;
   logic [3:0] bitcnt;
   logic [7:0] shreg, txsh;
   logic       ack_ph, m_ack, wr_seen;
   logic       rx_phase, rx_done, ack_end, cmd_ok, tx_load;
   logic       ctr_load, ctr_page, ctr_seq;
   logic [AW-1:0] addr_q;

   assign rx_phase = (st == ST_CMD) || (st == ST_ADDR) || (st == ST_WDATA);
   assign rx_done  = rx_phase && scl_fall && !ack_ph && (bitcnt == 4'd8);
   assign ack_end  = rx_phase && scl_fall && ack_ph;
   assign cmd_ok   = (shreg[7:4] == DEV_NIBBLE) && !busy;
   assign tx_load  = (ack_end && (st == ST_CMD) && shreg[0]) ||
                     ((st == ST_RDATA) && scl_fall && (bitcnt == 4'd8) && m_ack);
   assign ctr_load = rx_done && (st == ST_ADDR);
   assign ctr_page = rx_done && (st == ST_WDATA);
   assign ctr_seq  = tx_load && !start_ev && !stop_ev;

   twi_addr_ctr #(.AW(AW), .ROLL(ROLL)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(shreg[AW-1:0]),
      .inc_seq(ctr_seq), .inc_page(ctr_page), .addr(addr_q));

   assign rd_addr = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         txsh     <= '0;
         ack_ph   <= 1'b0;
         m_ack    <= 1'b0;
         wr_seen  <= 1'b0;
         sda_pull <= 1'b0;
         wr_valid <= 1'b0;
         wr_stop  <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_valid <= 1'b0;
         wr_stop  <= 1'b0;
         if (start_ev) begin
            st       <= ST_CMD;
            bitcnt   <= '0;
            ack_ph   <= 1'b0;
            sda_pull <= 1'b0;
            wr_seen  <= 1'b0;
         end else if (stop_ev) begin
            st       <= ST_IDLE;
            ack_ph   <= 1'b0;
            sda_pull <= 1'b0;
            wr_stop  <= wr_seen;
            wr_seen  <= 1'b0;
         end else if (st == ST_RDATA) begin
            if (scl_rise && bitcnt == 4'd8)
               m_ack <= ~sda_c;
            if (scl_fall) begin
               if (bitcnt < 4'd7) begin
                  txsh     <= {txsh[6:0], 1'b0};
                  sda_pull <= ~txsh[6];
                  bitcnt   <= bitcnt + 4'd1;
               end else if (bitcnt == 4'd7) begin
                  sda_pull <= 1'b0;
                  bitcnt   <= 4'd8;
               end else if (m_ack) begin
                  txsh     <= rd_data;
                  sda_pull <= ~rd_data[7];
                  bitcnt   <= '0;
               end else begin
                  st <= ST_IDLE;
               end
            end
         end else if (rx_phase) begin
            if (scl_rise && !ack_ph && bitcnt < 4'd8) begin
               shreg  <= {shreg[6:0], sda_c};
               bitcnt <= bitcnt + 4'd1;
            end
            if (rx_done) begin
               if (st == ST_CMD && !cmd_ok) begin
                  st <= ST_IDLE;
               end else begin
                  ack_ph   <= 1'b1;
                  sda_pull <= 1'b1;
               end
               if (st == ST_WDATA) begin
                  wr_valid <= 1'b1;
                  wr_addr  <= addr_q;
                  wr_data  <= shreg;
                  wr_seen  <= 1'b1;
               end
            end
            if (ack_end) begin
               ack_ph   <= 1'b0;
               sda_pull <= 1'b0;
               bitcnt   <= '0;
               if (st == ST_CMD && shreg[0]) begin
                  st       <= ST_RDATA;
                  txsh     <= rd_data;
                  sda_pull <= ~rd_data[7];
               end else if (st == ST_CMD) begin
                  st <= ST_ADDR;
               end else begin
                  st <= ST_WDATA;
               end
            end
         end
      end
   end
endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk #(
   parameter int AW   = 8,
   parameter bit ROLL = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_c,
   input logic             start_ev,
   input logic             stop_ev,
   input logic             sda_pull,
   input logic             busy,
   input logic             wr_valid,
   input logic             wr_stop,
   input logic [AW-1:0]    rd_addr,
   input twi_pkg::twi_st_e st
);
   import twi_pkg::*;

   assert_pull_steady_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_c && $past(scl_c) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_pull));

   assert_no_ack_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_CMD) && $rose(sda_pull)) |-> !$past(busy));

   assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_pull);

   assert_wr_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);

   assert_stop_pulse_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stop |-> (st == ST_IDLE));

   assert_read_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(st) == ST_RDATA) && (st == ST_RDATA) && (rd_addr != $past(rd_addr)))
      |-> (rd_addr == AW'($past(rd_addr) + 1'b1)));

   generate
      if (!ROLL) begin : g_sat_chk
         assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (($past(st) == ST_RDATA) && (st == ST_RDATA)) |-> (rd_addr >= $past(rd_addr)));
      end
   endgenerate
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk #(.AW(AW), .ROLL(ROLL)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_c(scl_c), .start_ev(start_ev), .stop_ev(stop_ev),
   .sda_pull(sda_pull), .busy(busy), .wr_valid(wr_valid), .wr_stop(wr_stop),
   .rd_addr(rd_addr), .st(st));

// File: tb/twi_eeprom_slave_bench.sv
`timescale 1ns/1ps
module twi_eeprom_slave_bench;
   localparam int MEM = 256;
   localparam int AW  = $clog2(MEM);
   localparam int TOP = MEM - 1;
   localparam int Q   = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scl_m = 1'b1;
   logic          sda_m = 1'b1;
   logic          busy = 1'b0;
   logic          sda_pull;
   logic          sda_in;
   logic [AW-1:0] rd_addr;
   logic [7:0]    rd_data = 8'h00;
   logic          wr_valid;
   logic [AW-1:0] wr_addr;
   logic [7:0]    wr_data;
   logic          wr_stop;

   int n_chk = 0;
   int n_bad = 0;
   int stop_cnt = 0;
   int wq[$];
   int rq[$];

   always #10 clk = ~clk;

   assign sda_in = sda_m & ~sda_pull;

   twi_eeprom_slave #(.MEM_BYTES(MEM)) u_twi_eeprom_slave (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_in),
      .sda_pull(sda_pull), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_stop(wr_stop));

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 11) ^ (a >> 3));
   endfunction

   function automatic int nxt(input int a);
      if (MEM == 256) return (a + 1) % 256;
      return (a == TOP) ? TOP : a + 1;
   endfunction

   always @(posedge clk) rd_data <= pat(int'(rd_addr));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: write strobes against the expected queue
   always @(negedge clk) begin
      if (rst_n && wr_valid) begin
         if (wq.size() == 0) begin
            chk(1'b0, "R6 unexpected write strobe", {int'(wr_addr), int'(wr_data)}, 0);
         end else begin
            automatic int e = wq.pop_front();
            chk((int'(wr_addr) == (e >> 8)) && (int'(wr_data) == (e & 255)),
                "R6 write strobe", int'(wr_addr) * 256 + int'(wr_data), e);
         end
      end
      if (rst_n && wr_stop) stop_cnt++;
   end

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; w(Q);
      scl_m = 1'b1; w(2*Q);
      sda_m = 1'b0; w(2*Q);
      scl_m = 1'b0; w(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; w(Q);
      scl_m = 1'b1; w(2*Q);
      sda_m = 1'b1; w(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i];
         if (glitch && i == 4) begin
            w(2); scl_m = 1'b1; w(1); scl_m = 1'b0;
         end
         w(Q);
         scl_m = 1'b1; w(2*Q);
         scl_m = 1'b0; w(Q);
      end
      sda_m = 1'b1; w(Q);
      scl_m = 1'b1; w(Q);
      acked = ~sda_in;
      w(Q);
      scl_m = 1'b0; w(Q);
   endtask

   task automatic send_chk(input logic [7:0] b, input bit exp_ack, input string tag);
      bit a;
      send_byte(b, 1'b0, a);
      chk(a == exp_ack, tag, a, exp_ack);
   endtask

   task automatic rd_byte(input bit mack, input logic [7:0] expv, input string tag);
      logic [7:0] got;
      rq.push_back(int'(expv));
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; w(Q);
         scl_m = 1'b1; w(Q);
         got[i] = sda_in;
         w(Q);
         scl_m = 1'b0; w(Q);
      end
      sda_m = mack ? 1'b0 : 1'b1; w(Q);
      scl_m = 1'b1; w(2*Q);
      scl_m = 1'b0; w(Q);
      sda_m = 1'b1;
      begin
         automatic int e = rq.pop_front();
         chk(int'(got) == e, tag, int'(got), e);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit a;
      w(5);
      rst_n = 1'b1;
      w(3);
      chk(sda_pull == 1'b0, "R1 pull low after reset", sda_pull, 0);
      chk(rd_addr == '0, "R1 pointer zero after reset", int'(rd_addr), 0);
      chk(!wr_valid && !wr_stop, "R1 strobes idle", {wr_valid, wr_stop}, 0);

      // R8 current-address read straight after reset
      bus_start();
      send_chk(8'hA1, 1'b1, "R3 read command acked");
      rd_byte(1'b0, pat(0), "R8 current read at 0");
      bus_stop();

      // R5/R6 write two bytes, second with a clock glitch (R11)
      bus_start();
      send_chk(8'hA0, 1'b1, "R3 write command acked");
      send_chk(8'h10, 1'b1, "R5 address acked");
      wq.push_back(16'h105A);
      send_chk(8'h5A, 1'b1, "R6 data acked");
      wq.push_back(16'h1133);
      send_byte(8'h33, 1'b1, a);
      chk(a, "R11 glitched byte acked", a, 1);
      bus_stop();
      w(4);
      chk(stop_cnt == 1, "R7 stop pulse after write", stop_cnt, 1);
      chk(int'(rd_addr) == 8'h12, "R6 pointer after two writes", int'(rd_addr), 8'h12);

      // R6 page wrap
      bus_start();
      send_chk(8'hA0, 1'b1, "R3 write command acked");
      send_chk(8'h16, 1'b1, "R5 address acked");
      wq.push_back(16'h16C1); send_chk(8'hC1, 1'b1, "R6 data acked");
      wq.push_back(16'h17C2); send_chk(8'hC2, 1'b1, "R6 data acked");
      wq.push_back(16'h10C3); send_chk(8'hC3, 1'b1, "R6 page wrap data acked");
      bus_stop();
      w(4);
      chk(stop_cnt == 2, "R7 stop pulse after page write", stop_cnt, 2);
      chk(int'(rd_addr) == 8'h11, "R6 pointer wrapped in page", int'(rd_addr), 8'h11);

      // R7 address only: no stop pulse
      bus_start();
      send_chk(8'hA0, 1'b1, "R3 write command acked");
      send_chk(8'h30, 1'b1, "R5 address acked");
      bus_stop();
      w(4);
      chk(stop_cnt == 2, "R7 no stop pulse without data", stop_cnt, 2);
      chk(int'(rd_addr) == 8'h30, "R5 pointer loaded", int'(rd_addr), 8'h30);

      // R2/R3 wrong device nibble
      bus_start();
      send_chk(8'hB1, 1'b0, "R3 wrong nibble not acked");
      send_chk(8'h55, 1'b0, "R2 byte after refused command ignored");
      bus_stop();
      chk(int'(rd_addr) == 8'h30, "R2 pointer untouched", int'(rd_addr), 8'h30);

      // R2 clocking without START
      scl_m = 1'b0; w(Q);
      send_chk(8'hA1, 1'b0, "R2 no ack without start");
      bus_stop();

      // R3 don't-care bits set, sequential read
      bus_start();
      send_chk(8'hAF, 1'b1, "R3 bits 3..1 ignored");
      rd_byte(1'b1, pat(8'h30), "R8 read at 30");
      rd_byte(1'b0, pat(8'h31), "R8 sequential read at 31");
      bus_stop();

      // R8 random read via repeated start
      bus_start();
      send_chk(8'hA0, 1'b1, "R3 write command acked");
      send_chk(8'h40, 1'b1, "R5 address acked");
      bus_start();
      send_chk(8'hA1, 1'b1, "R3 read command acked");
      rd_byte(1'b1, pat(8'h40), "R8 random read at 40");
      rd_byte(1'b0, pat(8'h41), "R8 random read at 41");
      bus_stop();
      w(4);
      chk(stop_cnt == 2, "R7 no stop pulse after read", stop_cnt, 2);

      // R9 busy refuses both directions
      busy = 1'b1;
      bus_start();
      send_chk(8'hA1, 1'b0, "R9 read refused while busy");
      bus_stop();
      bus_start();
      send_chk(8'hA0, 1'b0, "R9 write refused while busy");
      bus_stop();
      busy = 1'b0;
      bus_start();
      send_chk(8'hA1, 1'b1, "R9 read acked after busy");
      rd_byte(1'b0, pat(8'h42), "R8 current read kept pointer");
      bus_stop();

      // R10 top of memory
      bus_start();
      send_chk(8'hA0, 1'b1, "R3 write command acked");
      send_chk(8'(TOP - 1), 1'b1, "R5 address acked");
      bus_start();
      send_chk(8'hA1, 1'b1, "R3 read command acked");
      rd_byte(1'b1, pat(TOP - 1), "R10 read below top");
      rd_byte(1'b1, pat(TOP), "R10 read top");
      rd_byte(1'b1, pat(nxt(TOP)), "R10 read past top");
      rd_byte(1'b0, pat(nxt(nxt(TOP))), "R10 read two past top");
      bus_stop();

      w(10);
      chk(wq.size() == 0, "R6 all expected writes seen", wq.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule